// File: doc/BRIEF.md
# Per-Channel Oversampling Conversion Sequencer

This block paces a multi-channel converter. A single programmable timer fires a one-cycle convert pulse at a fixed spacing. The block announces which channel that conversion belongs to. Each raw 16-bit result comes back on a valid/data input. The block steps through the enabled channels in ascending index order. It spends a per-channel number of conversions on each one: 1, 4, 16 or 64. It adds those results, scales the sum down, and emits one widened, tagged sample per channel.

A channel with ratio 4^k yields a sample that is 16+k bits wide, at the convert rate divided by 4^k. One full pass produces one sample per enabled channel. A pass lasts the sum of the enabled channels' ratios times the convert period. The enable mask and the ratio fields are sampled only when a pass begins. They may therefore be rewritten at any time without splitting a channel's group of conversions.

The converter is expected to return each result before the next convert pulse. Result strobes that arrive while no conversion is pending are discarded.

Top module: `osq_sequencer`

## Requirements
- R1: Channel i takes its ratio from ratio_cfg bits [2i+1:2i], coded 00=1, 01=4, 10=16, 11=64. For code k, exactly 4^k accepted results are consumed per output sample, and the reset default of every field is 00.
- R2: For code k the output sample equals the sum of its 4^k unsigned results shifted right by k bits. It is zero-extended to 19 bits, so no bit at or above position 16+k is set.
- R3: While a pass is active, conv_pulse is high for exactly one cycle every P cycles, where P is the effective period. The spacing is unchanged across channel and pass boundaries.
- R4: The effective period P is period_cfg clock cycles, and values below 2 are raised to 2. Two convert pulses are never adjacent.
- R5: Enabled channels are visited in ascending index order, and disabled channels receive no conversions. conv_chan holds the channel of the conversion being signalled while conv_pulse is high.
- R6: Each sample carries its channel index on smp_chan. smp_last is 1 exactly for the sample of the highest enabled channel of the pass.
- R7: Changes to chan_en or ratio_cfg during a pass do not affect that pass. They take effect from the first conversion of the next pass.
- R8: An all-zero enable mask sampled at a pass start stops the convert pulses and produces no samples. This includes the state after reset.
- R9: A res_valid strobe that arrives while no conversion is pending is ignored and does not change any later sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Channel enable mask, bit i enables channel i |
| ratio_cfg | input | 2*NCH | Per-channel 2-bit oversampling ratio codes |
| period_cfg | input | PERW | Convert period in clock cycles (minimum 2) |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Raw unsigned conversion result |
| conv_pulse | output | 1 | One-cycle start-of-conversion pulse |
| conv_chan | output | clog2(NCH) | Channel of the signalled conversion |
| smp_valid | output | 1 | Output sample strobe |
| smp_data | output | 19 | Reduced sample, zero-extended |
| smp_chan | output | clog2(NCH) | Channel of the output sample |
| smp_last | output | 1 | Sample is the final one of its pass |

## Verification
The bench builds the block with NCH=4 and PERW=8. Four channels are enough for masks with holes, a disabled top channel and a single-channel pass. An 8-bit period keeps the clamped values 0 and 1 within reach, along with short periods that make full passes fast. Constant all-ones results at ratio 64 reach the largest 19-bit sample. Pseudo-random results at mixed ratios check the sum-and-shift. A mid-pass rewrite of the mask and ratios checks that the pass boundary is honoured.

// File: rtl/osq_pkg.sv
package osq_pkg;
  localparam int RAW_W = 16;
  localparam int OUT_W = 19;
  localparam int ACC_W = RAW_W + 6;

  typedef logic [1:0] osr_code_t;

  // Index of the final conversion of a group: 4^k - 1
  function automatic logic [6:0] osr_last_idx(osr_code_t c);
    case (c)
      2'd0:    return 7'd0;
      2'd1:    return 7'd3;
      2'd2:    return 7'd15;
      default: return 7'd63;
    endcase
  endfunction

  // Sum of 4^k results scaled by 2^-k, giving 16+k significant bits
  function automatic logic [OUT_W-1:0] osr_reduce(logic [ACC_W-1:0] s, osr_code_t c);
    logic [ACC_W-1:0] t;
    t = s >> c;
    return t[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/osq_timer.sv
module osq_timer #(
  parameter int PERW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PERW-1:0] period,
  output logic            tick
);
  logic [PERW-1:0] per_eff;
  logic [PERW-1:0] cnt_q;

  assign per_eff = (period < PERW'(2)) ? PERW'(2) : period;
  assign tick    = run && (cnt_q >= per_eff - PERW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + PERW'(1);
  end

  // R4: clamped period keeps ticks apart
  a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/osq_pick.sv
module osq_pick #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW:0]   lo,
  output logic [CHW-1:0] nxt,
  output logic           found
);
  // Lowest enabled index at or above lo
  always_comb begin
    nxt   = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && ((CHW+1)'(i) >= lo)) begin
        nxt   = CHW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/osq_accum.sv
module osq_accum
  import osq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [RAW_W-1:0]     din,
  input  osr_code_t            code,
  output logic                 fin,
  output logic [ACC_W-1:0]     acc_o,
  output logic [OUT_W-1:0]     red_o
);
  logic [5:0]       n_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum   = acc_q + ACC_W'(din);
  assign fin   = take && ({1'b0, n_q} == osr_last_idx(code));
  assign acc_o = acc_q;
  assign red_o = osr_reduce(sum, code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (take) begin
      if (fin) begin
        acc_q <= '0;
        n_q   <= '0;
      end else begin
        acc_q <= sum;
        n_q   <= n_q + 6'd1;
      end
    end
  end

  // R1: group count never passes the channel's ratio
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, n_q} <= osr_last_idx(code));
endmodule

// File: rtl/osq_sequencer.sv
module osq_sequencer
  import osq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int PERW = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     chan_en,
  input  logic [2*NCH-1:0]   ratio_cfg,
  input  logic [PERW-1:0]    period_cfg,
  input  logic               res_valid,
  input  logic [RAW_W-1:0]   res_data,
  output logic               conv_pulse,
  output logic [CHW-1:0]     conv_chan,
  output logic               smp_valid,
  output logic [OUT_W-1:0]   smp_data,
  output logic [CHW-1:0]     smp_chan,
  output logic               smp_last
);
  logic             active_q, pend_q, pulse_q;
  logic [NCH-1:0]   en_q;
  logic [2*NCH-1:0] ratio_q;
  logic [CHW-1:0]   cur_q;
  osr_code_t        k_out_q;

  // Named internal events
  logic             tick, take, fin, more, any_en, pass_end;
  logic [CHW-1:0]   nxt_ch, first_ch;
  osr_code_t        cur_code;
  logic [ACC_W-1:0] acc_now;
  logic [OUT_W-1:0] red_now;

  assign cur_code = ratio_q[2*cur_q +: 2];
  assign take     = res_valid && pend_q;
  assign pass_end = fin && !more;

  osq_timer #(.PERW(PERW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(active_q), .period(period_cfg), .tick(tick)
  );

  osq_pick #(.NCH(NCH), .CHW(CHW)) u_next (
    .mask(en_q), .lo({1'b0, cur_q} + (CHW+1)'(1)), .nxt(nxt_ch), .found(more)
  );

  osq_pick #(.NCH(NCH), .CHW(CHW)) u_first (
    .mask(chan_en), .lo('0), .nxt(first_ch), .found(any_en)
  );

  osq_accum u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .din(res_data), .code(cur_code),
    .fin(fin), .acc_o(acc_now), .red_o(red_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      pend_q    <= 1'b0;
      pulse_q   <= 1'b0;
      en_q      <= '0;
      ratio_q   <= '0;
      cur_q     <= '0;
      k_out_q   <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_chan  <= '0;
      smp_last  <= 1'b0;
    end else begin
      pulse_q   <= tick;
      smp_valid <= fin;
      if (tick)      pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
      if (fin) begin
        smp_data <= red_now;
        smp_chan <= cur_q;
        smp_last <= !more;
        k_out_q  <= cur_code;
      end
      if (!active_q || pass_end) begin
        en_q     <= chan_en;
        ratio_q  <= ratio_cfg;
        cur_q    <= first_ch;
        active_q <= any_en;
      end else if (fin) begin
        cur_q    <= nxt_ch;
      end
    end
  end

  assign conv_pulse = pulse_q;
  assign conv_chan  = cur_q;

  // R8: an idle sequencer issues no convert pulse
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !conv_pulse);

  // R5: every pulse targets a channel enabled for the pass
  a_r5_chan_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pulse |-> en_q[conv_chan]);

  // R2: sample fits 16+k bits
  a_r2_width: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ((smp_data >> (5'd16 + {3'b000, k_out_q})) == '0));

  // R9: strobe without a pending conversion leaves the sum alone
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !pend_q) |=> $stable(acc_now));
endmodule

// File: tb/sim_osq_sequencer.sv
module sim_osq_sequencer;
  localparam int NCH  = 4;
  localparam int PERW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NCH-1:0]   chan_en = '0;
  logic [2*NCH-1:0] ratio_cfg = '0;
  logic [PERW-1:0]  period_cfg = 8'd4;
  logic             res_valid = 1'b0;
  logic [15:0]      res_data = '0;
  logic             conv_pulse, smp_valid, smp_last;
  logic [1:0]       conv_chan, smp_chan;
  logic [18:0]      smp_data;

  osq_sequencer #(.NCH(NCH), .PERW(PERW)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ratio_cfg(ratio_cfg),
    .period_cfg(period_cfg), .res_valid(res_valid), .res_data(res_data),
    .conv_pulse(conv_pulse), .conv_chan(conv_chan), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_chan(smp_chan), .smp_last(smp_last)
  );

  int checks = 0, errors = 0, cyc = 0, np = 0, ns = 0, seed_v = 0;
  logic [1:0]  pch [1024];
  logic [15:0] pdat[1024];
  int          pcyc[1024];
  logic [18:0] sd  [1024];
  logic [1:0]  sc  [1024];
  logic        sl  [1024];
  bit          const_mode = 1'b0;
  bit          stray_req = 1'b0;
  logic [15:0] v;

  always @(posedge clk) cyc++;

  // Converter model: answers each pulse one cycle later
  always @(negedge clk) begin
    res_valid <= 1'b0;
    if (conv_pulse) begin
      v = const_mode ? 16'hFFFF : 16'(seed_v * 40503 + 977);
      seed_v++;
      if (np < 1024) begin
        pch[np] = conv_chan; pdat[np] = v; pcyc[np] = cyc;
      end
      np++;
      res_valid <= 1'b1;
      res_data  <= v;
    end else if (stray_req) begin
      res_valid <= 1'b1;
      res_data  <= 16'hFFFF;
      stray_req = 1'b0;
    end
    if (smp_valid) begin
      if (ns < 1024) begin
        sd[ns] = smp_data; sc[ns] = smp_chan; sl[ns] = smp_last;
      end
      ns++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic restart(logic [3:0] m, logic [7:0] r, logic [7:0] per, bit cm);
    @(negedge clk);
    rst_n = 1'b0;
    chan_en = m; ratio_cfg = r; period_cfg = per; const_mode = cm;
    repeat (3) @(negedge clk);
    np = 0; ns = 0; seed_v = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_samples(int n);
    for (int t = 0; t < 20000 && ns < n; t++) @(negedge clk);
  endtask

  // Independent model of passes: A-config passes, then B-config passes
  task automatic verify(string tag, int pa, logic [3:0] ma, logic [7:0] ra,
                        int pb, logic [3:0] mb, logic [7:0] rb);
    int p = 0;
    int s = 0;
    for (int pass = 0; pass < pa + pb; pass++) begin
      logic [3:0] m;
      logic [7:0] r;
      int hi;
      m = (pass < pa) ? ma : mb;
      r = (pass < pa) ? ra : rb;
      hi = 0;
      for (int c = 0; c < 4; c++) if (m[c]) hi = c;
      for (int c = 0; c < 4; c++) begin
        if (m[c]) begin
          int k;
          int n;
          longint sum;
          k = int'(r[2*c +: 2]);
          n = 1 << (2 * k);
          sum = 0;
          for (int j = 0; j < n; j++) begin
            chk({tag, " R1 R5 R7 pulse channel"}, 32'(pch[p]), 32'(c));
            sum += longint'(pdat[p]);
            p++;
          end
          chk({tag, " R2 sample value"}, 32'(sd[s]), 32'(sum >> k));
          chk({tag, " R6 sample channel"}, 32'(sc[s]), 32'(c));
          chk({tag, " R6 last flag"}, 32'(sl[s]), 32'(c == hi));
          s++;
        end
      end
    end
  endtask

  task automatic t_reset;
    restart(4'b0000, 8'h00, 8'd4, 1'b0);
    repeat (20) @(negedge clk);
    chk("R8 no pulse with empty mask", 32'(np), 0);
    chk("R8 no sample with empty mask", 32'(ns), 0);
    chk("R8 reset pulse low", 32'(conv_pulse), 0);
    chk("R8 reset sample strobe low", 32'(smp_valid), 0);
  endtask

  task automatic t_basic;
    restart(4'b1011, 8'b10_00_01_00, 8'd5, 1'b0);
    wait_samples(6);
    verify("basic", 2, 4'b1011, 8'b10_00_01_00, 0, 4'b0, 8'b0);
    chk("R3 spacing first pulses", 32'(pcyc[1] - pcyc[0]), 5);
    chk("R3 spacing across pass boundary", 32'(pcyc[21] - pcyc[20]), 5);
  endtask

  task automatic t_full;
    restart(4'b0001, 8'b00_00_00_11, 8'd0, 1'b1);
    wait_samples(2);
    chk("R2 largest ratio-64 sample", 32'(sd[0]), 32'h7FFF8);
    chk("R2 largest sample second pass", 32'(sd[1]), 32'h7FFF8);
    chk("R4 period 0 raised to 2", 32'(pcyc[1] - pcyc[0]), 2);
    chk("R3 spacing across pass boundary", 32'(pcyc[64] - pcyc[63]), 2);
    period_cfg = 8'd1;
    repeat (8) @(negedge clk);
    chk("R4 period 1 raised to 2", 32'(pcyc[np-1] - pcyc[np-2]), 2);
  endtask

  task automatic t_cfg;
    restart(4'b0110, 8'b00_01_01_00, 8'd3, 1'b0);
    for (int t = 0; t < 2000 && np < 2; t++) @(negedge clk);
    chan_en = 4'b1001;
    ratio_cfg = 8'b01_00_00_00;
    wait_samples(6);
    verify("cfg R7", 1, 4'b0110, 8'b00_01_01_00, 2, 4'b1001, 8'b01_00_00_00);
  endtask

  task automatic t_stray;
    restart(4'b0100, 8'b00_01_00_00, 8'd6, 1'b0);
    for (int t = 0; t < 2000 && np < 2; t++) @(negedge clk);
    @(posedge clk);
    stray_req = 1'b1;
    wait_samples(2);
    verify("stray R9", 2, 4'b0100, 8'b00_01_00_00, 0, 4'b0, 8'b0);
  endtask

  task automatic t_stop;
    restart(4'b0011, 8'h00, 8'd3, 1'b0);
    for (int t = 0; t < 2000 && np < 1; t++) @(negedge clk);
    chan_en = 4'b0000;
    wait_samples(2);
    repeat (40) @(negedge clk);
    chk("R8 pulses stop after emptied mask", 32'(np), 2);
    chk("R8 samples stop after emptied mask", 32'(ns), 2);
    chk("R6 last flag of stopping pass", 32'(sl[1]), 1);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    t_basic();
    t_full();
    t_cfg();
    t_stray();
    t_stop();
    summary();
  end
endmodule